// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character per request into an asynchronous serial frame on a single line. The sender offers a character with a valid/ready handshake. While the block is idle and the mode is legal it raises `tx_ready`. On acceptance it captures the character, the frame format and the divider setting, then drives the start bit, the data bits with the least significant bit first, an optional parity bit and one or two stop bits. After that it returns to idle.

Bit timing comes from an 8-bit reload divider. A setting `n` gives a prescale of `n+1` clocks, and a fixed divide by 16 follows it, so one bit lasts `(n+1)*16` clocks. Both counters restart when a character is accepted, so the start bit is aligned to the handshake.

The controller has five states. IDLE goes to START when a character is accepted. START goes to DATA at the end of its bit period. DATA stays in DATA until its last data bit ends. At that point it goes to PARITY when parity is enabled, and to STOP otherwise. PARITY goes to STOP at the end of its bit period. STOP stays for a second bit period when two stop bits are selected, and then goes back to IDLE.

Top module: `uart_frame_tx`

## Requirements
- R1: The mode code selects the character length. Code 100 gives 7 data bits, 101 gives 8 and 110 gives 9. Data bits go out least significant bit first, one per bit period, right after the start bit.
- R2: Any other mode code, including 000, disables the block. `tx_ready` stays low, nothing is accepted, `busy` stays low and the line idles.
- R3: A character is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. The start bit, at level 0 before inversion, appears on `txd` in the next cycle.
- R4: With `cfg_par_en` = 1, a parity bit follows the last data bit. With `cfg_par_even` = 0 the number of ones in the data bits plus the parity bit is odd. With `cfg_par_even` = 1 that number is even.
- R5: `cfg_two_stop` = 0 sends one stop bit at level 1 before inversion, and 1 sends two.
- R6: `cfg_invert` = 1 inverts every bit on the line: the idle level, start, data, parity and stop bits.
- R7: With divider setting `n` (0 to 255), every bit lasts exactly `(n+1)*16` clock cycles.
- R8: `busy` is high from the cycle after acceptance for exactly F*(n+1)*16 cycles, where F = 1 + data bits + parity bits + stop bits. `tx_ready` is low while `busy` is high.
- R9: Format and divider are captured at acceptance. Changing any configuration input during a frame does not alter that frame.
- R10: Data input bits above the selected character length are neither sent nor counted in parity.
- R11: While `busy` is high, `txd` changes only at bit-period boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 9 | Character to send, bit 0 first |
| tx_valid | input | 1 | A character is offered |
| tx_ready | output | 1 | The block can accept a character this cycle |
| cfg_mode | input | 3 | Mode code: 100/101/110 for 7/8/9 bits, others disable |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_even | input | 1 | 0 = odd parity, 1 = even parity |
| cfg_two_stop | input | 1 | 0 = one stop bit, 1 = two |
| cfg_invert | input | 1 | Invert the whole line, idle level included |
| cfg_div | input | 8 | Divider setting n; the bit period is (n+1)*16 clocks |
| busy | output | 1 | A frame is in progress |
| txd | output | 1 | Serial line |

## Verification
Counting from the acceptance edge as cycle 0, bit k of the frame covers cycles k*B up to (k+1)*B-1, where B = (n+1)*16. `busy` must still be high in cycle F*B-1 and low in cycle F*B. The bench counts falling edges after the acceptance edge and samples `txd` in the first and in the last cycle of every bit, so a period that is one cycle short or long is caught. It checks `busy` and `tx_ready` exactly at the frame-end boundary. It sweeps every legal mode, parity and stop setting, with both polarities, at the smallest divider, then runs larger dividers up to 255, a configuration change in mid-frame, and disabled codes held against a valid request.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_MAX = 9;
    localparam int CNT_W    = $clog2(DATA_MAX + 1);

    localparam logic [2:0] MODE_OFF = 3'b000;
    localparam logic [2:0] MODE_C7  = 3'b100;
    localparam logic [2:0] MODE_C8  = 3'b101;
    localparam logic [2:0] MODE_C9  = 3'b110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    // Character length for a mode code; zero marks a disabled or illegal code.
    function automatic logic [CNT_W-1:0] char_len(input logic [2:0] code);
        logic [CNT_W-1:0] len;
        case (code)
            MODE_C7:  len = CNT_W'(7);
            MODE_C8:  len = CNT_W'(8);
            MODE_C9:  len = CNT_W'(9);
            MODE_OFF: len = '0;
            default:  len = '0;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int DIV_W = 8,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             bit_tick
);
    localparam int OVS_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS - 1);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] pre_q;
    logic [OVS_W-1:0] ovs_q;
    logic             pre_wrap;
    logic             ovs_wrap;

    assign pre_wrap = (pre_q == div_q);
    assign ovs_wrap = (ovs_q == OVS_LAST);
    assign bit_tick = run && pre_wrap && ovs_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            pre_q <= '0;
            ovs_q <= '0;
        end else if (clear) begin
            div_q <= div;
            pre_q <= '0;
            ovs_q <= '0;
        end else if (!run) begin
            pre_q <= '0;
            ovs_q <= '0;
        end else if (pre_wrap) begin
            pre_q <= '0;
            ovs_q <= ovs_wrap ? '0 : ovs_q + OVS_W'(1);
        end else begin
            pre_q <= pre_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/uart_tx_fmt.sv
module uart_tx_fmt
    import uart_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                shift,
    input  logic [DATA_MAX-1:0] data,
    input  logic [CNT_W-1:0]    n_bits_in,
    input  logic                par_en_in,
    input  logic                par_even_in,
    input  logic                two_stop_in,
    input  logic                invert_in,
    output logic                data_bit,
    output logic                par_bit,
    output logic [CNT_W-1:0]    n_bits,
    output logic                par_en,
    output logic                two_stop,
    output logic                invert
);
    logic [DATA_MAX-1:0] masked;
    logic [DATA_MAX-1:0] shreg_q;
    logic                par_d;
    logic                par_q;

    // Keep only the bits that belong to the selected character length.
    for (genvar gi = 0; gi < DATA_MAX; gi++) begin : g_mask
        assign masked[gi] = data[gi] & (n_bits_in > CNT_W'(gi));
    end

    assign par_d = par_even_in ? (^masked) : ~(^masked);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            par_q    <= 1'b0;
            n_bits   <= CNT_W'(8);
            par_en   <= 1'b0;
            two_stop <= 1'b0;
            invert   <= 1'b0;
        end else if (load) begin
            shreg_q  <= masked;
            par_q    <= par_d;
            n_bits   <= n_bits_in;
            par_en   <= par_en_in;
            two_stop <= two_stop_in;
            invert   <= invert_in;
        end else if (shift) begin
            shreg_q  <= {1'b0, shreg_q[DATA_MAX-1:1]};
        end
    end

    assign data_bit = shreg_q[0];
    assign par_bit  = par_q;
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
    import uart_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             bit_tick,
    input  logic [CNT_W-1:0] n_bits,
    input  logic             par_en,
    input  logic             two_stop,
    input  logic             data_bit,
    input  logic             par_bit,
    output logic             shift,
    output logic             busy,
    output logic             line_raw
);
    tx_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_START;
                    cnt_d   = '0;
                end
            end
            ST_START: begin
                if (bit_tick) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_tick) begin
                    if (cnt_q == n_bits - CNT_W'(1)) begin
                        cnt_d   = '0;
                        state_d = par_en ? ST_PARITY : ST_STOP;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            ST_PARITY: begin
                if (bit_tick) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (bit_tick) begin
                    if (two_stop && cnt_q == '0) begin
                        cnt_d = CNT_W'(1);
                    end else begin
                        cnt_d   = '0;
                        state_d = ST_IDLE;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        busy  = (state_q != ST_IDLE);
        shift = (state_q == ST_DATA) && bit_tick;
        unique case (state_q)
            ST_IDLE:   line_raw = 1'b1;
            ST_START:  line_raw = 1'b0;
            ST_DATA:   line_raw = data_bit;
            ST_PARITY: line_raw = par_bit;
            ST_STOP:   line_raw = 1'b1;
            default:   line_raw = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int OVS   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_MAX-1:0] tx_data,
    input  logic                tx_valid,
    output logic                tx_ready,
    input  logic [2:0]          cfg_mode,
    input  logic                cfg_par_en,
    input  logic                cfg_par_even,
    input  logic                cfg_two_stop,
    input  logic                cfg_invert,
    input  logic [DIV_W-1:0]    cfg_div,
    output logic                busy,
    output logic                txd
);
    logic [CNT_W-1:0] len_cfg;
    logic             mode_ok;
    logic             accept;
    logic             bit_tick;
    logic             shift;
    logic             line_raw;
    logic             data_bit;
    logic             par_bit;
    logic [CNT_W-1:0] n_bits;
    logic             par_en;
    logic             two_stop;
    logic             inv_q;

    assign len_cfg  = char_len(cfg_mode);
    assign mode_ok  = (len_cfg != '0);
    assign tx_ready = mode_ok && !busy;
    assign accept   = tx_valid && tx_ready;

    uart_tx_baud #(
        .DIV_W (DIV_W),
        .OVS   (OVS)
    ) baud_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .run      (busy),
        .div      (cfg_div),
        .bit_tick (bit_tick)
    );

    uart_tx_fmt fmt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .shift       (shift),
        .data        (tx_data),
        .n_bits_in   (len_cfg),
        .par_en_in   (cfg_par_en),
        .par_even_in (cfg_par_even),
        .two_stop_in (cfg_two_stop),
        .invert_in   (cfg_invert),
        .data_bit    (data_bit),
        .par_bit     (par_bit),
        .n_bits      (n_bits),
        .par_en      (par_en),
        .two_stop    (two_stop),
        .invert      (inv_q)
    );

    uart_tx_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .bit_tick (bit_tick),
        .n_bits   (n_bits),
        .par_en   (par_en),
        .two_stop (two_stop),
        .data_bit (data_bit),
        .par_bit  (par_bit),
        .shift    (shift),
        .busy     (busy),
        .line_raw (line_raw)
    );

    // The frame polarity is frozen at acceptance; the idle level follows the live input.
    assign txd = line_raw ^ (busy ? inv_q : cfg_invert);
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [2:0] cfg_mode,
    input logic       cfg_invert,
    input logic       busy,
    input logic       txd,
    input logic       bit_tick
);
    // R2
    disabled_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_mode inside {3'b100, 3'b101, 3'b110}) |-> !tx_ready);

    // R8
    ready_excludes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !busy);

    // R8
    busy_rise_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tx_valid && tx_ready));

    // R3
    start_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (busy && txd == $past(cfg_invert)));

    // R6
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (txd == !cfg_invert));

    // R11
    line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(txd)) |-> $past(bit_tick));
endmodule

bind uart_frame_tx uart_frame_tx_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .cfg_mode   (cfg_mode),
    .cfg_invert (cfg_invert),
    .busy       (busy),
    .txd        (txd),
    .bit_tick   (bit_tick)
);

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;
    localparam time CLK_P = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [2:0] cfg_mode = 3'b101;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_invert = 1'b0;
    logic [7:0] cfg_div = 8'd0;
    logic       busy;
    logic       txd;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    uart_frame_tx dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .cfg_mode     (cfg_mode),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_even (cfg_par_even),
        .cfg_two_stop (cfg_two_stop),
        .cfg_invert   (cfg_invert),
        .cfg_div      (cfg_div),
        .busy         (busy),
        .txd          (txd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Sends one character and checks every bit boundary of its frame.
    task automatic run_frame(input logic [8:0] d, input logic [2:0] mode, input bit pe,
                             input bit pev, input bit ts, input bit inv,
                             input logic [7:0] div, input bit mid_change, input string tag);
        int  n, f, b, idx, ones, wait_n;
        logic e [0:15];
        string base;
        n = (mode == 3'b100) ? 7 : (mode == 3'b101) ? 8 : 9;
        f = 1 + n + (pe ? 1 : 0) + (ts ? 2 : 1);
        b = (int'(div) + 1) * 16;
        ones = 0;
        e[0] = 1'b0;
        for (int i = 0; i < n; i++) begin
            e[1 + i] = d[i];
            ones += int'(d[i]);
        end
        idx = 1 + n;
        if (pe) begin
            e[idx] = pev ? logic'(ones % 2) : logic'(1 - ones % 2);
            idx++;
        end
        for (int i = idx; i < 16; i++) e[i] = 1'b1;

        @(negedge clk);
        cfg_mode = mode; cfg_par_en = pe; cfg_par_even = pev;
        cfg_two_stop = ts; cfg_invert = inv; cfg_div = div;
        @(negedge clk);
        wait_n = 0;
        while (!tx_ready && wait_n < 100000) begin
            @(negedge clk);
            wait_n++;
        end
        tx_data = d;
        tx_valid = 1'b1;
        @(posedge clk);
        for (int j = 0; j <= f * b; j++) begin
            @(negedge clk);
            if (j == 0) begin
                tx_valid = 1'b0;
                tx_data = ~d;
                check(txd == inv, {"R3 start bit in cycle after accept", tag}, int'(txd), int'(inv));
            end
            if (mid_change && j == b / 2) begin
                cfg_mode = 3'b000; cfg_par_en = ~pe; cfg_par_even = ~pev;
                cfg_two_stop = ~ts; cfg_invert = ~inv; cfg_div = div + 8'd3;
            end
            if (j < f * b && ((j % b) == 0 || (j % b) == b - 1)) begin
                int k;
                k = j / b;
                if (k == 0) base = "R3 start";
                else if (k <= n) base = "R1 data";
                else if (pe && k == n + 1) base = "R4 parity";
                else base = "R5 stop";
                if (inv) base = {base, " R6"};
                if ((j % b) == b - 1) base = {base, " R7 end-of-bit"};
                check(txd == (e[k] ^ inv), {base, tag}, int'(txd), int'(e[k] ^ inv));
            end
            if (j == f * b - 1)
                check(busy == 1'b1, {"R8 busy through last stop", tag}, int'(busy), 1);
            if (j == f * b) begin
                check(busy == 1'b0, {"R7 R8 busy low after frame", tag}, int'(busy), 0);
                if (!mid_change)
                    check(tx_ready == 1'b1, {"R8 ready after frame", tag}, int'(tx_ready), 1);
            end
        end
        if (mid_change) begin
            @(negedge clk);
            cfg_mode = mode; cfg_invert = inv;
        end
    endtask

    task automatic check_disabled(input logic [2:0] mode, input bit inv);
        @(negedge clk);
        cfg_mode = mode;
        cfg_invert = inv;
        tx_valid = 1'b1;
        tx_data = 9'h0A5;
        for (int j = 0; j < 40; j++) begin
            @(negedge clk);
            if (j % 10 == 9) begin
                check(tx_ready == 1'b0, "R2 ready low when disabled", int'(tx_ready), 0);
                check(busy == 1'b0, "R2 busy low when disabled", int'(busy), 0);
                check(txd == !inv, "R2 R6 line idle when disabled", int'(txd), int'(!inv));
            end
        end
        tx_valid = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(busy == 1'b0, "R8 reset busy", int'(busy), 0);
        check(txd == 1'b1, "R6 reset idle level", int'(txd), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_ready == 1'b1, "R2 ready after reset", int'(tx_ready), 1);

        check_disabled(3'b000, 1'b0);
        check_disabled(3'b000, 1'b1);
        check_disabled(3'b111, 1'b0);
        check_disabled(3'b011, 1'b1);

        // Full format sweep at the fastest divider.
        for (int m = 0; m < 3; m++)
            for (int c = 0; c < 16; c++) begin
                logic [8:0] d;
                d = 9'((m * 16 + c) * 149 + 77);
                run_frame(d, 3'(3'b100 + m), c[0], c[1], c[2], c[3], 8'd0, 1'b0, "");
            end

        // R10: upper bits beyond the character length are ignored.
        run_frame(9'h180, 3'b100, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0, 1'b0, " R10");
        run_frame(9'h100, 3'b101, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, " R10");
        run_frame(9'h1FF, 3'b100, 1'b1, 1'b0, 1'b1, 1'b1, 8'd1, 1'b0, " R10");

        // R7: other divider settings.
        run_frame(9'h155, 3'b110, 1'b1, 1'b1, 1'b1, 1'b0, 8'd1, 1'b0, " R7");
        run_frame(9'h03C, 3'b101, 1'b0, 1'b0, 1'b0, 1'b1, 8'd2, 1'b0, " R7");
        run_frame(9'h0C3, 3'b100, 1'b1, 1'b0, 1'b1, 1'b0, 8'd5, 1'b0, " R7");
        run_frame(9'h0A6, 3'b101, 1'b0, 1'b0, 1'b0, 1'b0, 8'd255, 1'b0, " R7 max divider");

        // R9: configuration moved during the frame.
        run_frame(9'h1B2, 3'b110, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, " R9");
        run_frame(9'h04D, 3'b101, 1'b0, 1'b1, 1'b1, 1'b1, 8'd0, 1'b1, " R9");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule